// File: doc/BRIEF.md
# Power-Management Control Register

This block is a 16-bit control register for system power management. It sits on a simple I/O-style register bus and answers at a fixed offset of 04h above a base address that is supplied as an input. Software uses it to choose a sleep state and then trigger entry into that state. It can also raise a firmware interrupt request (SMI) through a release bit, enable a break event driven by bus-master activity, and enable the system control interrupt (SCI) from four event status lines.

The register itself stores only the 3-bit sleep-type field and two enable bits. The sleep trigger (bit 13) and the release bit (bit 2) act as write pulses and always read back as zero. When a valid sleep request is written, the block issues a one-cycle request that carries the stored sleep type. A release write issues a one-cycle SMI request and sets a sticky firmware status flag, but only when the external firmware enable input is 1. A bus-master status rising edge produces one break event when that event is enabled. The SCI output is a gated OR of the four event status inputs.

Top module: `pm_ctrl_reg`

## Requirements
- R1: After reset the register reads 0000h, and slp_req, smi_req, bios_sts, brk_evt and sci are all 0.
- R2: A write lands only when bus_wr is 1 and bus_addr equals io_base + 04h. bus_rdata shows the register when bus_addr equals io_base + 04h and shows 0000h at any other address. Writes to any other address change nothing.
- R3: The read value is {2'b00, 1'b0, type[2:0] in bits 12:10, 7'b0, 1'b0 in bit 2, brk_en in bit 1, sci_en in bit 0}. Bits 15:14, 13, 9:3 and 2 always read 0, whatever was written to them.
- R4: A write with bus_be[1]=1 and wdata[13]=1 stores wdata[12:10] as the type. If that type is 0 to 5 (0 soft-off, 1 RAM, 2 powered-on/context lost, 3 powered-on/CPU context lost, 4 powered-on/context kept, 5 working), slp_req is 1 for exactly the one cycle after the write, and slp_type shows the stored type.
- R5: When the type written together with bit 13 is 6 or 7 (reserved), no slp_req is issued, although the type is still stored.
- R6: The type field keeps its value after a sleep request. Writing type 5 with bit 13 at 0, or any type with bit 13 at 0, issues no request.
- R7: A write with bus_be[1]=0 leaves the type unchanged and issues no slp_req, even when wdata[13]=1. A write with bus_be[0]=0 leaves bits 1:0 unchanged and raises no SMI.
- R8: A write with bus_be[0]=1 and wdata[2]=1 while bios_en=1 makes smi_req 1 for the one cycle after the write and sets bios_sts. With bios_en=0 it does neither.
- R9: bios_sts stays 1 until bios_sts_clr is 1 at a clock edge. When a set and a clear occur in the same cycle, the set wins.
- R10: With bit 1 set, each 0-to-1 change of bm_sts makes brk_evt 1 for exactly one cycle, one cycle after the edge. No event occurs while bm_sts stays high, and none occurs when bit 1 is clear.
- R11: sci equals bit 0 AND (pwrbtn_sts OR lid_sts OR thrm_sts OR gpi_sts), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_base | input | 16 | Base address of the power-management I/O block |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables: bit 0 is the low byte, bit 1 is the high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| bios_en | input | 1 | Firmware enable that allows release writes to take effect |
| bios_sts_clr | input | 1 | Clears the firmware status flag |
| bm_sts | input | 1 | Bus-master status |
| pwrbtn_sts | input | 1 | Power-button event status |
| lid_sts | input | 1 | Lid event status |
| thrm_sts | input | 1 | Thermal event status |
| gpi_sts | input | 1 | General-purpose input event status |
| slp_req | output | 1 | One-cycle sleep request |
| slp_type | output | 3 | Stored sleep type |
| smi_req | output | 1 | One-cycle SMI request |
| bios_sts | output | 1 | Sticky firmware status flag |
| brk_evt | output | 1 | One-cycle bus-master break event |
| sci | output | 1 | System control interrupt |

## Verification
A wrong stored type or enable bit shows up on bus_rdata at the very next read, and in slp_type at once. A broken trigger path shows up as a missing, misplaced or stretched pulse. Because every pulse is registered, any error appears exactly one cycle after the write or edge that caused it. A lost or stuck status flag stays visible on bios_sts until the next clear, so it can be seen at any later sample.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned PMC_W   = 16;
  localparam int unsigned TRIG_B  = 13;
  localparam int unsigned TYP_LSB = 10;
  localparam int unsigned TYP_W   = 3;
  localparam int unsigned GBL_B   = 2;
  localparam int unsigned BRK_B   = 1;
  localparam int unsigned SCI_B   = 0;
  localparam int unsigned N_EVT   = 4;

  typedef enum logic [TYP_W-1:0] {
    SLP_SOFTOFF  = 3'd0,
    SLP_RAM      = 3'd1,
    SLP_PO_LOST  = 3'd2,
    SLP_PO_CPU   = 3'd3,
    SLP_PO_KEPT  = 3'd4,
    SLP_WORKING  = 3'd5,
    SLP_RSV_A    = 3'd6,
    SLP_RSV_B    = 3'd7
  } slp_kind_e;

  // A sleep kind may start a request only if it is not one of the reserved codes.
  function automatic logic slp_kind_ok(input logic [TYP_W-1:0] k);
    return k <= SLP_WORKING;
  endfunction

  // Readback image: only the stored fields appear, and everything else reads as zero.
  function automatic logic [PMC_W-1:0] pmc_image(input logic [TYP_W-1:0] typ,
                                                 input logic brk, input logic sci);
    logic [PMC_W-1:0] v;
    v = '0;
    v[TYP_LSB +: TYP_W] = typ;
    v[BRK_B] = brk;
    v[SCI_B] = sci;
    return v;
  endfunction
endpackage

// File: rtl/pmc_regbank.sv
module pmc_regbank
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [PMC_W-1:0]  bus_wdata,
  output logic [PMC_W-1:0]  bus_rdata,
  output logic [TYP_W-1:0]  typ,
  output logic              brk_en,
  output logic              sci_en,
  output logic              slp_req,
  output logic              gbl_wr
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [ADDR_W-1:0] OFS_V = ADDR_W'(OFFSET);

  logic [ADDR_W-1:0] reg_addr;
  logic              hit_w, wr_hi, wr_lo, slp_fire;

  assign reg_addr = io_base + OFS_V;
  assign hit_w    = (bus_addr == reg_addr);
  assign wr_hi    = bus_wr && hit_w && bus_be[1];
  assign wr_lo    = bus_wr && hit_w && bus_be[0];
  assign slp_fire = wr_hi && bus_wdata[TRIG_B] && slp_kind_ok(bus_wdata[TYP_LSB +: TYP_W]);
  assign gbl_wr   = wr_lo && bus_wdata[GBL_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ     <= SLP_SOFTOFF;
      brk_en  <= 1'b0;
      sci_en  <= 1'b0;
      slp_req <= 1'b0;
    end else begin
      if (wr_hi) typ <= bus_wdata[TYP_LSB +: TYP_W];
      if (wr_lo) begin
        brk_en <= bus_wdata[BRK_B];
        sci_en <= bus_wdata[SCI_B];
      end
      slp_req <= slp_fire;
    end
  end

  assign bus_rdata = hit_w ? pmc_image(typ, brk_en, sci_en) : '0;

  AST_SLP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req |-> $past(wr_hi && bus_wdata[TRIG_B])); // R4
  AST_SLP_KIND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req |-> slp_kind_ok(typ)); // R5
  AST_TYPE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hi) |-> $stable(typ)); // R7
endmodule

// File: rtl/pmc_events.sv
module pmc_events
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gbl_wr,
  input  logic             bios_en,
  input  logic             bios_sts_clr,
  input  logic             brk_en,
  input  logic             sci_en,
  input  logic             bm_sts,
  input  logic [N_EVT-1:0] evt_sts,
  output logic             smi_req,
  output logic             bios_sts,
  output logic             brk_evt,
  output logic             sci
);
  timeunit 1ns; timeprecision 100ps;

  logic bm_q, bm_rise, smi_fire;

  assign smi_fire = gbl_wr && bios_en;
  assign bm_rise  = bm_sts && !bm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_req  <= 1'b0;
      bios_sts <= 1'b0;
      bm_q     <= 1'b0;
      brk_evt  <= 1'b0;
    end else begin
      smi_req <= smi_fire;
      if (smi_fire)          bios_sts <= 1'b1;
      else if (bios_sts_clr) bios_sts <= 1'b0;
      bm_q    <= bm_sts;
      brk_evt <= brk_en && bm_rise;
    end
  end

  assign sci = sci_en && (|evt_sts);

  AST_SMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(bios_en && gbl_wr)); // R8
  AST_STS_WITH_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> bios_sts); // R9
  AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt); // R10
  AST_BRK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> $past(brk_en && bm_sts)); // R10
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              bios_en,
  input  logic              bios_sts_clr,
  input  logic              bm_sts,
  input  logic              pwrbtn_sts,
  input  logic              lid_sts,
  input  logic              thrm_sts,
  input  logic              gpi_sts,
  output logic              slp_req,
  output logic [2:0]        slp_type,
  output logic              smi_req,
  output logic              bios_sts,
  output logic              brk_evt,
  output logic              sci
);
  timeunit 1ns; timeprecision 100ps;

  logic [TYP_W-1:0] typ_w;
  logic             brk_en_w, sci_en_w, gbl_wr_w;
  logic [N_EVT-1:0] evt_w;

  assign evt_w = {gpi_sts, thrm_sts, lid_sts, pwrbtn_sts};

  pmc_regbank #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .typ(typ_w), .brk_en(brk_en_w), .sci_en(sci_en_w), .slp_req(slp_req),
    .gbl_wr(gbl_wr_w)
  );

  pmc_events u_evts (
    .clk(clk), .rst_n(rst_n), .gbl_wr(gbl_wr_w), .bios_en(bios_en),
    .bios_sts_clr(bios_sts_clr), .brk_en(brk_en_w), .sci_en(sci_en_w),
    .bm_sts(bm_sts), .evt_sts(evt_w), .smi_req(smi_req), .bios_sts(bios_sts),
    .brk_evt(brk_evt), .sci(sci)
  );

  assign slp_type = typ_w;

  AST_SCI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_en_w |-> !sci); // R11
  AST_SLP_TYPE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req |-> (slp_type == bus_rdata[12:10] || bus_rdata == 16'h0)); // R4
endmodule

// File: tb/sim_pm_ctrl_reg.sv
module sim_pm_ctrl_reg;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_base = 16'h0400, bus_addr = 16'h0, bus_wdata = 16'h0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_be = 2'b00;
  logic bios_en = 1'b0, bios_sts_clr = 1'b0, bm_sts = 1'b0;
  logic pwrbtn_sts = 1'b0, lid_sts = 1'b0, thrm_sts = 1'b0, gpi_sts = 1'b0;
  logic [15:0] bus_rdata;
  logic slp_req, smi_req, bios_sts, brk_evt, sci;
  logic [2:0] slp_type;

  int n_chk = 0, n_fail = 0;

  // Bench model of the stored state.
  logic [2:0] m_typ = 3'd0;
  logic m_brk = 1'b0, m_sci = 1'b0, m_sts = 1'b0;

  always #2.5 clk = ~clk;

  pm_ctrl_reg u0 (.*);

  function automatic logic [15:0] exp_image(input logic [2:0] t, input logic b, input logic s);
    return {3'b000, t, 8'h00, b, s};
  endfunction

  function automatic logic exp_trigger(input logic [1:0] be, input logic [15:0] d);
    return be[1] && d[13] && (d[12:10] < 3'd6);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd_chk(input string req);
    bus_addr = io_base + 16'h4;
    #0.5;
    chk(bus_rdata == exp_image(m_typ, m_brk, m_sci), req, bus_rdata, exp_image(m_typ, m_brk, m_sci));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1");
    chk({slp_req, smi_req, bios_sts, brk_evt, sci} == 5'b0, "R1", {11'b0, slp_req, smi_req, bios_sts, brk_evt, sci}, 16'h0);

    // R3 reserved and pulse bits read zero
    wr(io_base + 16'h4, 2'b11, 16'hC3FB & ~16'h2000);
    m_typ = 3'd0; m_brk = 1'b1; m_sci = 1'b1;
    rd_chk("R3");
    wr(io_base + 16'h4, 2'b11, 16'h0000);
    m_brk = 1'b0; m_sci = 1'b0;

    // R4 valid request, pulse one cycle after write, type shown
    wr(io_base + 16'h4, 2'b10, 16'h2000 | (16'd1 << 10));
    m_typ = 3'd1;
    chk(slp_req == 1'b1, "R4", {15'b0, slp_req}, 16'h1);
    chk(slp_type == 3'd1, "R4", {13'b0, slp_type}, 16'h1);
    @(negedge clk);
    chk(slp_req == 1'b0, "R4", {15'b0, slp_req}, 16'h0);
    // R6 type kept after the request
    rd_chk("R6");

    // R5 reserved codes: no request, type still stored
    for (int c = 6; c < 8; c++) begin
      wr(io_base + 16'h4, 2'b10, 16'h2000 | (16'(c) << 10));
      m_typ = 3'(c);
      chk(slp_req == 1'b0, "R5", {15'b0, slp_req}, 16'h0);
      rd_chk("R5");
    end

    // R6 writing working type without trigger does nothing
    wr(io_base + 16'h4, 2'b10, 16'd5 << 10);
    m_typ = 3'd5;
    chk(slp_req == 1'b0, "R6", {15'b0, slp_req}, 16'h0);
    rd_chk("R6");

    // R7 low byte only: trigger bit ignored, type unchanged
    wr(io_base + 16'h4, 2'b01, 16'h2000 | (16'd2 << 10));
    chk(slp_req == 1'b0, "R7", {15'b0, slp_req}, 16'h0);
    rd_chk("R7");

    // R2 other address and moved base
    wr(io_base + 16'h6, 2'b11, 16'h2403);
    chk(slp_req == 1'b0, "R2", {15'b0, slp_req}, 16'h0);
    rd_chk("R2");
    bus_addr = io_base + 16'h8; #0.5;
    chk(bus_rdata == 16'h0, "R2", bus_rdata, 16'h0);
    io_base = 16'h1000;
    wr(16'h1004, 2'b01, 16'h0001);
    m_sci = 1'b1;
    rd_chk("R2");

    // R8 release without enable
    bios_en = 1'b0;
    wr(io_base + 16'h4, 2'b01, 16'h0005);
    chk(smi_req == 1'b0 && bios_sts == 1'b0, "R8", {14'b0, smi_req, bios_sts}, 16'h0);
    // R8 release with enable
    bios_en = 1'b1;
    wr(io_base + 16'h4, 2'b01, 16'h0005);
    m_sts = 1'b1;
    chk(smi_req == 1'b1 && bios_sts == 1'b1, "R8", {14'b0, smi_req, bios_sts}, 16'h3);
    @(negedge clk);
    chk(smi_req == 1'b0, "R8", {15'b0, smi_req}, 16'h0);
    // R9 sticky, then clear
    repeat (3) @(negedge clk);
    chk(bios_sts == 1'b1, "R9", {15'b0, bios_sts}, 16'h1);
    bios_sts_clr = 1'b1; @(negedge clk); bios_sts_clr = 1'b0;
    chk(bios_sts == 1'b0, "R9", {15'b0, bios_sts}, 16'h0);
    // R9 set wins over clear in the same cycle
    @(negedge clk);
    bus_addr = io_base + 16'h4; bus_be = 2'b01; bus_wdata = 16'h0005; bus_wr = 1'b1; bios_sts_clr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00; bios_sts_clr = 1'b0;
    chk(bios_sts == 1'b1, "R9", {15'b0, bios_sts}, 16'h1);
    bios_sts_clr = 1'b1; @(negedge clk); bios_sts_clr = 1'b0;
    m_sts = 1'b0;

    // R11 SCI gating over all status combinations
    for (int e = 0; e < 2; e++) begin
      wr(io_base + 16'h4, 2'b01, 16'(e));
      m_sci = e[0]; m_brk = 1'b0;
      for (int s = 0; s < 16; s++) begin
        {gpi_sts, thrm_sts, lid_sts, pwrbtn_sts} = 4'(s);
        #0.5;
        chk(sci == (e[0] && s != 0), "R11", {15'b0, sci}, {15'b0, (e[0] && s != 0)});
      end
    end
    {gpi_sts, thrm_sts, lid_sts, pwrbtn_sts} = 4'h0;

    // R10 break event disabled
    @(negedge clk); bm_sts = 1'b1;
    @(negedge clk);
    chk(brk_evt == 1'b0, "R10", {15'b0, brk_evt}, 16'h0);
    bm_sts = 1'b0;
    wr(io_base + 16'h4, 2'b01, 16'h0002);
    m_brk = 1'b1; m_sci = 1'b0;
    bm_sts = 1'b1;
    @(negedge clk);
    chk(brk_evt == 1'b1, "R10", {15'b0, brk_evt}, 16'h1);
    @(negedge clk);
    chk(brk_evt == 1'b0, "R10", {15'b0, brk_evt}, 16'h0);
    repeat (2) @(negedge clk);
    chk(brk_evt == 1'b0, "R10", {15'b0, brk_evt}, 16'h0);
    bm_sts = 1'b0; @(negedge clk);
    bm_sts = 1'b1; @(negedge clk);
    chk(brk_evt == 1'b1, "R10", {15'b0, brk_evt}, 16'h1);
    bm_sts = 1'b0;

    // Random phase: R2, R4, R5, R7, R8 against the bench model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, d;
      logic [1:0] be;
      logic hit, exp_slp, exp_smi;
      a  = ($urandom % 4 != 0) ? io_base + 16'h4 : io_base + 16'($urandom % 16);
      be = 2'($urandom);
      d  = 16'($urandom);
      if ($urandom % 2 == 0) d[13] = 1'b1;
      bios_en = 1'($urandom);
      hit = (a == io_base + 16'h4);
      exp_slp = hit && exp_trigger(be, d);
      exp_smi = hit && be[0] && d[2] && bios_en;
      wr(a, be, d);
      if (hit && be[1]) m_typ = d[12:10];
      if (hit && be[0]) begin m_brk = d[1]; m_sci = d[0]; end
      if (exp_smi) m_sts = 1'b1;
      chk(slp_req == exp_slp, "R4", {15'b0, slp_req}, {15'b0, exp_slp});
      chk(slp_type == m_typ, "R4", {13'b0, slp_type}, {13'b0, m_typ});
      chk(smi_req == exp_smi, "R8", {15'b0, smi_req}, {15'b0, exp_smi});
      chk(bios_sts == m_sts, "R9", {15'b0, bios_sts}, {15'b0, m_sts});
      rd_chk("R2");
    end
    finish_run();
  end
endmodule